// File: doc/BRIEF.md
# Multi-Rate RTC Tick Prescaler

The prescaler turns a slow reference clock into the timing strobes that a real-time clock needs. The reference runs at one of three rates: 32768 Hz, 32000 Hz or 38400 Hz. From it the block makes a 512 Hz base strobe. A 9-bit binary counter then divides that strobe down to the 256 Hz through 2 Hz periodic strobes and to a 1 Hz strobe for the seconds counter. The two references that are not powers of two need a divider whose modulus is not fixed. At 38400 Hz the divider uses a constant modulus of 75. At 32000 Hz it alternates between 62 and 63, which averages 62.5 reference cycles per base strobe.

The whole block runs in the reference clock domain. Its inputs are a plain enable level and a 2-bit source select. Its outputs are plain single-cycle strobes with no handshake, because a tick cannot be held back. Disabling the block, choosing the reserved source code or changing the source clears the divider and the binary counter. The next tick is therefore always a full period away and never a short one.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `per_tick` is all zero and `sec_tick` is low.
- R2: With `src_sel` = 0 (32768 Hz) held steady and `enable` high, `per_tick[8]` (the 512 Hz base strobe) pulses every 64 cycles. The first pulse comes 64 cycles after `enable` rises.
- R3: With `src_sel` = 2 (38400 Hz), the base strobe pulses every 75 cycles. The first pulse comes 75 cycles after `enable` rises.
- R4: With `src_sel` = 1 (32000 Hz), the spacing of base strobes alternates between 62 and 63 cycles. The first base strobe after a restart comes 62 cycles after the enable.
- R5: Bit k of `per_tick` (k = 0 for 2 Hz, up to k = 8 for 512 Hz) pulses on every 2^(8-k)-th base strobe, counted from 1 after a restart, and only in a cycle where the base strobe pulses.
- R6: `sec_tick` pulses on every 512th base strobe. Every `per_tick` bit is high in the same cycle. The first pulse after `enable` rises comes 32768, 32000 or 38400 cycles later for codes 0, 1 and 2.
- R7: Every tick output is high for exactly one reference cycle at a time.
- R8: While `enable` is low, all outputs are low in that same cycle, and the divider and the binary counter are cleared. After `enable` rises again, the timing follows R2 to R5 from the start.
- R9: Code 3 on `src_sel` is reserved: no output ever pulses while it is applied.
- R10: A change of `src_sel` while enabled restarts the divider and the counter. The first base strobe comes one cycle plus the new modulus after the change, so no interval is shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one of the three supported rates |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low stops and clears all tick generation |
| src_sel | input | 2 | Reference rate code: 0 = 32768 Hz, 1 = 32000 Hz, 2 = 38400 Hz, 3 = reserved |
| per_tick | output | 9 | Periodic strobes, bit 0 = 2 Hz up to bit 8 = 512 Hz |
| sec_tick | output | 1 | One-second strobe |

## Verification
Only one register lies between the reference counter and the outputs. A strobe therefore appears in the cycle after the rising edge on which the divider reaches its terminal count. A new base period counts `mod` edges from an enable edge, and `mod + 1` edges from a source-select change, because the first edge only records the new code. The bench changes inputs and samples outputs on falling edges. At each falling edge it knows how many rising edges have passed since the stimulus, so every strobe is checked at its exact cycle. Gating on `enable` is combinational, so the bench checks it 1 ns after the input changes, inside the same cycle.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  typedef enum logic [1:0] {
    SRC_32K768 = 2'd0,
    SRC_32K000 = 2'd1,
    SRC_38K400 = 2'd2,
    SRC_RSVD   = 2'd3
  } rtc_src_e;

  // Largest base-strobe modulus any supported reference needs.
  localparam int unsigned MAX_BASE_DIV = 75;

  function automatic int unsigned cnt_width(input int unsigned max_div);
    return $clog2(max_div + 2);
  endfunction

endpackage

// File: rtl/rtc_src_decode.sv
module rtc_src_decode
  import rtc_tick_pkg::*;
#(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned DIV_POW2 = 64,
  parameter int unsigned DIV_FRAC = 62,
  parameter int unsigned DIV_INT  = 75
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] div_lo,
  output logic             alt,
  output logic             valid
);

  rtc_src_e src;
  assign src = rtc_src_e'(sel);

  always_comb begin
    div_lo = CNT_W'(DIV_POW2);
    alt    = 1'b0;
    valid  = 1'b1;
    unique case (src)
      SRC_32K768: div_lo = CNT_W'(DIV_POW2);
      SRC_32K000: begin
        div_lo = CNT_W'(DIV_FRAC);
        alt    = 1'b1;
      end
      SRC_38K400: div_lo = CNT_W'(DIV_INT);
      default:    valid  = 1'b0;
    endcase
  end

endmodule

// File: rtl/rtc_frac_div.sv
module rtc_frac_div #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] div_lo,
  input  logic             alt,
  output logic             base_tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic             tick_q;
  logic [CNT_W-1:0] term_cnt;

  // Alternating modulus: div_lo on even periods, div_lo + 1 on odd ones.
  assign term_cnt = div_lo - CNT_W'(1) + CNT_W'(alt & long_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      tick_q <= 1'b0;
    end else if (!run || restart) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      tick_q <= 1'b0;
    end else if (cnt_q == term_cnt) begin
      cnt_q  <= '0;
      long_q <= alt & ~long_q;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign base_tick = tick_q;

endmodule

// File: rtl/rtc_tick_chain.sv
module rtc_tick_chain #(
  parameter int unsigned CHAIN_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               base_tick,
  output logic [CHAIN_W-1:0] per_tick,
  output logic               sec_tick
);

  logic [CHAIN_W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stage_q <= '0;
    else if (clear)     stage_q <= '0;
    else if (base_tick) stage_q <= stage_q + CHAIN_W'(1);
  end

  // Bit k fires when the low (CHAIN_W-1-k) counter bits are all ones.
  genvar k;
  generate
    for (k = 0; k < CHAIN_W - 1; k++) begin : g_rate
      assign per_tick[k] = base_tick & (&stage_q[CHAIN_W-2-k:0]);
    end
  endgenerate
  assign per_tick[CHAIN_W-1] = base_tick;
  assign sec_tick            = base_tick & (&stage_q);

endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int unsigned CHAIN_W  = 9,
  parameter int unsigned DIV_POW2 = 64,
  parameter int unsigned DIV_FRAC = 62,
  parameter int unsigned DIV_INT  = 75
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         src_sel,
  output logic [CHAIN_W-1:0] per_tick,
  output logic               sec_tick
);

  localparam int unsigned CNT_W = cnt_width(MAX_BASE_DIV);

  logic [1:0]       sel_q;
  logic             restart;
  logic             run;
  logic [CNT_W-1:0] div_lo;
  logic             alt;
  logic             sel_ok;
  logic             base_tick;
  logic [CHAIN_W-1:0] chain_per;
  logic             chain_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= src_sel;
  end

  assign restart = (src_sel != sel_q);
  assign run     = enable & sel_ok;

  rtc_src_decode #(
    .CNT_W   (CNT_W),
    .DIV_POW2(DIV_POW2),
    .DIV_FRAC(DIV_FRAC),
    .DIV_INT (DIV_INT)
  ) u_decode (
    .sel   (src_sel),
    .div_lo(div_lo),
    .alt   (alt),
    .valid (sel_ok)
  );

  rtc_frac_div #(
    .CNT_W(CNT_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (restart),
    .div_lo   (div_lo),
    .alt      (alt),
    .base_tick(base_tick)
  );

  rtc_tick_chain #(
    .CHAIN_W(CHAIN_W)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~run | restart),
    .base_tick(base_tick),
    .per_tick (chain_per),
    .sec_tick (chain_sec)
  );

  assign per_tick = chain_per & {CHAIN_W{run}};
  assign sec_tick = chain_sec & run;

endmodule

// File: rtl/rtc_tick_prescaler_chk.sv
module rtc_tick_prescaler_chk #(
  parameter int unsigned CHAIN_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic [1:0]         src_sel,
  input logic [CHAIN_W-1:0] per_tick,
  input logic               sec_tick
);

  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (per_tick[CHAIN_W-1]) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hff) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  AST_BASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick[CHAIN_W-1] |=> !per_tick[CHAIN_W-1]); // R7
  AST_SEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R7
  AST_SEC_WITH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (&per_tick)); // R6
  AST_SLOW_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_tick[CHAIN_W-2:0]) |-> per_tick[CHAIN_W-1]); // R5
  AST_2HZ_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick[0] |-> (&per_tick[CHAIN_W-1:1])); // R5
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (per_tick == '0 && !sec_tick)); // R8
  AST_QUIET_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |-> (per_tick == '0 && !sec_tick)); // R9
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick[CHAIN_W-1] && seen_q) |-> (gap_q >= 8'd61)); // R10

endmodule

bind rtc_tick_prescaler rtc_tick_prescaler_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .src_sel (src_sel),
  .per_tick(per_tick),
  .sec_tick(sec_tick)
);

// File: tb/sim_rtc_tick_prescaler.sv
`timescale 1ns/1ps
module sim_rtc_tick_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [8:0] per_tick;
  logic       sec_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rtc_tick_prescaler u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .src_sel (src_sel),
    .per_tick(per_tick),
    .sec_tick(sec_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Count falling edges until the base strobe is seen (0 if never).
  task automatic wait_base(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (per_tick[8]) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic t_reset();
    enable  = 1'b1;
    src_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(per_tick == 9'd0 && !sec_tick, "R1 quiet in reset", int'(per_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(per_tick == 9'd0 && !sec_tick, "R1 quiet after release", int'(per_tick), 0);
    begin
      int n;
      wait_base(200, n);
      chk(n == 63, "R2 first base after reset", n + 1, 64);
      wait_base(200, n);
      chk(n == 64, "R2 base interval", n, 64);
    end
  endtask

  task automatic t_disable();
    int n;
    @(negedge clk);
    enable = 1'b0;
    src_sel = 2'd0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) wait_base(200, n);
    chk(per_tick[8] == 1'b1, "R8 base seen before disable", int'(per_tick[8]), 1);
    enable = 1'b0;
    #1;
    chk(per_tick == 9'd0 && !sec_tick, "R8 gated same cycle", int'(per_tick), 0);
    wait_base(150, n);
    chk(n == 0, "R8 no base while disabled", n, 0);
    enable = 1'b1;
    wait_base(200, n);
    chk(n == 64, "R8 first base after re-enable", n, 64);
    chk(per_tick[7] == 1'b0, "R8 counter cleared (256 Hz absent)", int'(per_tick[7]), 0);
    @(negedge clk);
    chk(per_tick[8] == 1'b0, "R7 base one cycle", int'(per_tick[8]), 0);
    wait_base(200, n);
    chk(n == 63 && per_tick[7], "R5 256 Hz on second base", int'(per_tick[7]), 1);
  endtask

  task automatic t_select();
    int n;
    repeat (40) @(negedge clk);
    src_sel = 2'd2;
    wait_base(300, n);
    chk(n == 76, "R10 first base after change to code 2", n, 76);
    wait_base(300, n);
    chk(n == 75, "R3 base interval code 2", n, 75);
    repeat (10) @(negedge clk);
    src_sel = 2'd3;
    #1;
    chk(per_tick == 9'd0, "R9 reserved quiet at once", int'(per_tick), 0);
    wait_base(300, n);
    chk(n == 0, "R9 no base on reserved code", n, 0);
    src_sel = 2'd0;
    wait_base(300, n);
    chk(n == 65, "R10 first base after code 3 to 0", n, 65);
  endtask

  task automatic t_second(input logic [1:0] code, input int total);
    int last = 0, idx = 0, n_sec = 0, at_sec = 0, bad_iv = 0, bad_pat = 0;
    int exp_iv, exp_ok;
    @(negedge clk);
    enable  = 1'b0;
    src_sel = code;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int i = 1; i <= total + 200; i++) begin
      @(negedge clk);
      if (per_tick[8]) begin
        idx++;
        if (code == 2'd0)      exp_iv = 64;
        else if (code == 2'd2) exp_iv = 75;
        else                   exp_iv = (idx % 2 == 1) ? 62 : 63;
        if (i - last != exp_iv) begin
          if (bad_iv == 0)
            chk(1'b0, code == 2'd1 ? "R4 base interval" : (code == 2'd2 ? "R3 base interval" : "R2 base interval"), i - last, exp_iv);
          bad_iv++;
        end
        last = i;
        for (int k = 0; k < 8; k++) begin
          exp_ok = ((idx % (1 << (8 - k))) == 0) ? 1 : 0;
          if (int'(per_tick[k]) != exp_ok) begin
            if (bad_pat == 0) chk(1'b0, "R5 rate pattern", k, exp_ok);
            bad_pat++;
          end
        end
        if (int'(sec_tick) != (((idx % 512) == 0) ? 1 : 0)) begin
          if (bad_pat == 0) chk(1'b0, "R6 sec on 512th base", idx, 512);
          bad_pat++;
        end
      end else if (per_tick != 9'd0 || sec_tick) begin
        if (bad_pat == 0) chk(1'b0, "R5 tick without base", int'(per_tick), 0);
        bad_pat++;
      end
      if (sec_tick) begin
        n_sec++;
        if (at_sec == 0) at_sec = i;
      end
    end
    chk(bad_iv == 0, code == 2'd1 ? "R4 all intervals" : "R2/R3 all intervals", bad_iv, 0);
    chk(bad_pat == 0, "R5 all rate patterns", bad_pat, 0);
    chk(at_sec == total, "R6 first second", at_sec, total);
    chk(n_sec == 1, "R7 single sec pulse", n_sec, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_disable();
    t_select();
    t_second(2'd0, 32768);
    t_second(2'd1, 32000);
    t_second(2'd2, 38400);
    summary();
  end

endmodule